// File: doc/BRIEF.md
# Fractional multi-modulus feedback divider sequencer

This block is the digital control for the feedback divider of a fractional-N synthesizer. It runs on the output clock of an external multi-modulus RF prescaler. Every cycle of that clock is one prescaler cycle, and the block uses `mod_sel` to tell the prescaler which modulus (64, 65, 68 or 73) to use for that cycle. It groups prescaler cycles into division periods. At the end of each period it raises `cmp_pulse` for one cycle; this pulse feeds the phase comparator.

The integer ratio N comes from four length fields and a 2-bit modulus-set field. A fractional accumulator with denominator 5 or 8 adds the numerator once per period. When the accumulator wraps, the next period is one VCO count longer (N+1), so the long-term ratio is N + NF/Q. New field values are taken in only at a period boundary.

The sequencer is a four-state machine. Each state is one prescaler segment: `SEG_73`, `SEG_68`, `SEG_65` and `SEG_64`. The transitions are as follows:
- *skip73to68*: `SEG_73` goes to `SEG_68` when the 68 segment is present.
- *skip73to65*: `SEG_73` goes to `SEG_65` when there is no 68 segment and the 65 segment is not empty.
- *skip73to64*: `SEG_73` goes to `SEG_64` when both the 68 and 65 segments are absent or empty.
- *step68to65*: `SEG_68` goes to `SEG_65` when the 65 segment is not empty.
- *step68to64*: `SEG_68` goes to `SEG_64` when the 65 segment is empty.
- *step65to64*: `SEG_65` goes to `SEG_64`.
- *wrap*: the last cycle of `SEG_64` goes to the first non-empty segment of the next period.
- *reset-load*: reset sets up the first period.

Top module: `frac_fb_divider`

## Requirements
- R1: `mod_set` selects the moduli used in a period: 1 = 64/65, 2 = 64/65/68, 3 = 64/65/68/73, 0 = 64/65/73. A modulus outside the set never appears on `mod_sel`, and the length fields of unused moduli have no effect. `mod_sel` encodes 0 = 64, 1 = 65, 2 = 68, 3 = 73.
- R2: Within one period the moduli appear in this order: all 73 cycles first, then all 68 cycles, then all 65 cycles, then all 64 cycles.
- R3: In one period, modulus 73 is used for `len73_m1`+1 cycles and modulus 68 for `len68_m1`+1 cycles. Modulus 65 is used for `len65` cycles, plus one more in a long period. Modulus 64 is used for `len64_m2`+2 cycles, minus one in a long period. A segment of length zero is skipped.
- R4: The VCO count of one period is (`len64_m2`+2)×64 + `len65`×65 + (`len68_m1`+1)×68 + (`len73_m1`+1)×73. Terms of unused moduli are left out, and a long period adds 1.
- R5: `cmp_pulse` is high for exactly one cycle per period: the last 64 cycle.
- R6: At each period end, the accumulator adds `frac_num`, modulo Q. Q is 5 when `frac_den8`=0 and 8 when `frac_den8`=1. A wrap makes the following period long.
- R7: A `frac_num` at or above Q is treated as Q−1.
- R8: If the stored accumulator value is at or above Q (after a switch from eighths to fifths), Q is subtracted from it once before the add.
- R9: All fields are sampled only at the clock edge that ends a period, or while reset is high. A change at any other time has no effect on the period in progress.
- R10: Reset is synchronous and active high. It clears the accumulator. The first cycle after reset starts a period that is built from the fields present during reset and is never long.
- R11: `len64_m2` is 12 bits wide. Its maximum value, 4095, gives 4097 cycles of modulus 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst | input | 1 | Synchronous reset, active high |
| len64_m2 | input | 12 | Cycles of modulus 64, minus 2 |
| len65 | input | 8 | Cycles of modulus 65 |
| len68_m1 | input | 4 | Cycles of modulus 68, minus 1 |
| len73_m1 | input | 4 | Cycles of modulus 73, minus 1 |
| mod_set | input | 2 | Modulus set selector |
| frac_num | input | 3 | Fractional numerator |
| frac_den8 | input | 1 | Denominator select: 0 = 5, 1 = 8 |
| mod_sel | output | 2 | Modulus for the current prescaler cycle |
| cmp_pulse | output | 1 | One-cycle pulse at the end of each period |

## Verification
A wrong state or count shows up on `mod_sel` in the same cycle. The bench sees it no later than the pulse that closes the affected period, as a wrong per-modulus count, a wrong VCO total or a modulus out of order. A wrong wrap point shows up as a pulse that is missing, extra or on the wrong modulus. An accumulator fault appears within at most Q periods, as a long period in the wrong place. The bench's own model predicts every period. The bench changes fields mid-period, switches the denominator, clamps the numerator and drives the longest 64 segment, so it can tell faults in sampling, wrap and length handling apart.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    // Segment states; the encoding doubles as the prescaler modulus code.
    typedef enum logic [1:0] {
        SEG_64 = 2'b00,
        SEG_65 = 2'b01,
        SEG_68 = 2'b10,
        SEG_73 = 2'b11
    } seg_e;

    localparam logic [1:0] SET_64_65       = 2'b01;
    localparam logic [1:0] SET_64_65_68    = 2'b10;
    localparam logic [1:0] SET_64_65_68_73 = 2'b11;
    localparam logic [1:0] SET_64_65_73    = 2'b00;

    function automatic logic set_has_73(input logic [1:0] s);
        return (s == SET_64_65_68_73) || (s == SET_64_65_73);
    endfunction

    function automatic logic set_has_68(input logic [1:0] s);
        return (s == SET_64_65_68) || (s == SET_64_65_68_73);
    endfunction

endpackage

// File: rtl/fdiv_accum.sv
module fdiv_accum #(
    parameter int NF_W    = 3,
    parameter int Q_SMALL = 5,
    parameter int Q_LARGE = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step,
    input  logic [NF_W-1:0] frac_num,
    input  logic            frac_den8,
    output logic            carry
);
    localparam int ACC_W = $clog2(Q_LARGE);
    localparam int SUM_W = ((NF_W > ACC_W) ? NF_W : ACC_W) + 1;
    localparam logic [SUM_W-1:0] QS = SUM_W'(Q_SMALL);
    localparam logic [SUM_W-1:0] QL = SUM_W'(Q_LARGE);

    logic [ACC_W-1:0] acc_q;
    logic [SUM_W-1:0] q_val, acc_ext, acc_fold, nf_ext, nf_eff, sum, wrapped;

    always_comb begin
        q_val    = frac_den8 ? QL : QS;
        acc_ext  = SUM_W'(acc_q);
        // a value left over from the larger denominator is folded once
        acc_fold = (acc_ext >= q_val) ? acc_ext - q_val : acc_ext;
        nf_ext   = SUM_W'(frac_num);
        nf_eff   = (nf_ext >= q_val) ? q_val - SUM_W'(1) : nf_ext;
        sum      = acc_fold + nf_eff;
        carry    = (sum >= q_val);
        wrapped  = carry ? sum - q_val : sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= ACC_W'(wrapped);
        end
    end
endmodule

// File: rtl/fdiv_plan.sv
module fdiv_plan
    import fdiv_pkg::*;
#(
    parameter int NM64_W = 12,
    parameter int NM65_W = 8,
    parameter int NM68_W = 4,
    parameter int NM73_W = 4,
    parameter int CNT_W  = 13
) (
    input  logic [NM64_W-1:0] len64_m2,
    input  logic [NM65_W-1:0] len65,
    input  logic [NM68_W-1:0] len68_m1,
    input  logic [NM73_W-1:0] len73_m1,
    input  logic [1:0]        mod_set,
    input  logic              carry,
    output logic [CNT_W-1:0]  seg73_len,
    output logic [CNT_W-1:0]  seg68_len,
    output logic [CNT_W-1:0]  seg65_len,
    output logic [CNT_W-1:0]  seg64_len,
    output seg_e              first_seg,
    output logic [CNT_W-1:0]  first_len
);
    always_comb begin
        seg73_len = set_has_73(mod_set) ? CNT_W'(len73_m1) + CNT_W'(1) : '0;
        seg68_len = set_has_68(mod_set) ? CNT_W'(len68_m1) + CNT_W'(1) : '0;
        // a long period trades one 64 cycle for a 65 cycle
        seg65_len = CNT_W'(len65) + CNT_W'(carry);
        seg64_len = CNT_W'(len64_m2) + CNT_W'(2) - CNT_W'(carry);

        if (seg73_len != '0) begin
            first_seg = SEG_73;
            first_len = seg73_len;
        end else if (seg68_len != '0) begin
            first_seg = SEG_68;
            first_len = seg68_len;
        end else if (seg65_len != '0) begin
            first_seg = SEG_65;
            first_len = seg65_len;
        end else begin
            first_seg = SEG_64;
            first_len = seg64_len;
        end
    end
endmodule

// File: rtl/fdiv_seq.sv
module fdiv_seq
    import fdiv_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] plan68,
    input  logic [CNT_W-1:0] plan65,
    input  logic [CNT_W-1:0] plan64,
    input  seg_e             plan_first,
    input  logic [CNT_W-1:0] plan_first_len,
    output logic [1:0]       mod_code,
    output logic             period_end
);
    seg_e             state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] k68_q, k68_d, k65_q, k65_d, k64_q, k64_d;
    logic             at_last;

    assign at_last = (cnt_q == CNT_W'(1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q - CNT_W'(1);
        k68_d   = k68_q;
        k65_d   = k65_q;
        k64_d   = k64_q;
        unique case (state_q)
            SEG_73: if (at_last) begin
                if (k68_q != '0) begin
                    state_d = SEG_68;
                    cnt_d   = k68_q;
                end else if (k65_q != '0) begin
                    state_d = SEG_65;
                    cnt_d   = k65_q;
                end else begin
                    state_d = SEG_64;
                    cnt_d   = k64_q;
                end
            end
            SEG_68: if (at_last) begin
                if (k65_q != '0) begin
                    state_d = SEG_65;
                    cnt_d   = k65_q;
                end else begin
                    state_d = SEG_64;
                    cnt_d   = k64_q;
                end
            end
            SEG_65: if (at_last) begin
                state_d = SEG_64;
                cnt_d   = k64_q;
            end
            SEG_64: if (at_last) begin
                state_d = plan_first;
                cnt_d   = plan_first_len;
                k68_d   = plan68;
                k65_d   = plan65;
                k64_d   = plan64;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= plan_first;
            cnt_q   <= plan_first_len;
            k68_q   <= plan68;
            k65_q   <= plan65;
            k64_q   <= plan64;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            k68_q   <= k68_d;
            k65_q   <= k65_d;
            k64_q   <= k64_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            SEG_73:  mod_code = 2'b11;
            SEG_68:  mod_code = 2'b10;
            SEG_65:  mod_code = 2'b01;
            default: mod_code = 2'b00;
        endcase
        period_end = (state_q == SEG_64) && at_last;
    end
endmodule

// File: rtl/frac_fb_divider.sv
module frac_fb_divider
    import fdiv_pkg::*;
#(
    parameter int NM64_W  = 12,
    parameter int NM65_W  = 8,
    parameter int NM68_W  = 4,
    parameter int NM73_W  = 4,
    parameter int NF_W    = 3,
    parameter int Q_SMALL = 5,
    parameter int Q_LARGE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NM64_W-1:0] len64_m2,
    input  logic [NM65_W-1:0] len65,
    input  logic [NM68_W-1:0] len68_m1,
    input  logic [NM73_W-1:0] len73_m1,
    input  logic [1:0]        mod_set,
    input  logic [NF_W-1:0]   frac_num,
    input  logic              frac_den8,
    output logic [1:0]        mod_sel,
    output logic              cmp_pulse
);
    localparam int W_A   = (NM64_W > NM65_W) ? NM64_W : NM65_W;
    localparam int W_B   = (NM68_W > NM73_W) ? NM68_W : NM73_W;
    localparam int CNT_W = ((W_A > W_B) ? W_A : W_B) + 1;

    logic             acc_carry, plan_carry;
    logic [CNT_W-1:0] s73, s68, s65, s64, f_len;
    seg_e             f_seg;

    fdiv_accum #(
        .NF_W(NF_W), .Q_SMALL(Q_SMALL), .Q_LARGE(Q_LARGE)
    ) u_accum (
        .clk(clk), .rst(rst), .step(cmp_pulse),
        .frac_num(frac_num), .frac_den8(frac_den8), .carry(acc_carry)
    );

    // the period set up during reset is never long
    assign plan_carry = acc_carry & ~rst;

    fdiv_plan #(
        .NM64_W(NM64_W), .NM65_W(NM65_W), .NM68_W(NM68_W),
        .NM73_W(NM73_W), .CNT_W(CNT_W)
    ) u_plan (
        .len64_m2(len64_m2), .len65(len65), .len68_m1(len68_m1),
        .len73_m1(len73_m1), .mod_set(mod_set), .carry(plan_carry),
        .seg73_len(s73), .seg68_len(s68), .seg65_len(s65), .seg64_len(s64),
        .first_seg(f_seg), .first_len(f_len)
    );

    fdiv_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst),
        .plan68(s68), .plan65(s65), .plan64(s64),
        .plan_first(f_seg), .plan_first_len(f_len),
        .mod_code(mod_sel), .period_end(cmp_pulse)
    );

    // s73 is consumed only through first_len
    logic unused_s73;
    assign unused_s73 = ^s73;
endmodule

// File: rtl/frac_fb_divider_chk.sv
module frac_fb_divider_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mod_set,
    input logic [1:0] mod_sel,
    input logic       cmp_pulse
);
    logic [1:0] set_q;
    logic       live;

    always_ff @(posedge clk) begin
        if (rst || cmp_pulse) set_q <= mod_set;
        live <= !rst;
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cmp_pulse |=> !cmp_pulse) else $error("pulse longer than one cycle"); // R5
    AST_PULSE_ON_64: assert property (@(posedge clk) disable iff (rst)
        cmp_pulse |-> (mod_sel == 2'b00)) else $error("pulse outside 64 segment"); // R5
    AST_DESCENDING: assert property (@(posedge clk) disable iff (rst)
        (live && !$past(cmp_pulse)) |-> (mod_sel <= $past(mod_sel))) else $error("modulus order"); // R2
    AST_SET_73: assert property (@(posedge clk) disable iff (rst)
        (mod_sel == 2'b11) |-> (set_q == 2'b11 || set_q == 2'b00)) else $error("73 outside set"); // R1
    AST_SET_68: assert property (@(posedge clk) disable iff (rst)
        (mod_sel == 2'b10) |-> set_q[1]) else $error("68 outside set"); // R1
endmodule

bind frac_fb_divider frac_fb_divider_chk u_chk (
    .clk(clk), .rst(rst), .mod_set(mod_set), .mod_sel(mod_sel), .cmp_pulse(cmp_pulse)
);

// File: tb/frac_fb_divider_test.sv
module frac_fb_divider_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] len64_m2 = '0;
    logic [7:0]  len65 = '0;
    logic [3:0]  len68_m1 = '0, len73_m1 = '0;
    logic [1:0]  mod_set = 2'b11;
    logic [2:0]  frac_num = '0;
    logic        frac_den8 = 1'b0;
    logic [1:0]  mod_sel;
    logic        cmp_pulse;

    always #2 clk = ~clk;

    frac_fb_divider uut (
        .clk(clk), .rst(rst), .len64_m2(len64_m2), .len65(len65),
        .len68_m1(len68_m1), .len73_m1(len73_m1), .mod_set(mod_set),
        .frac_num(frac_num), .frac_den8(frac_den8),
        .mod_sel(mod_sel), .cmp_pulse(cmp_pulse)
    );

    typedef struct {
        int c73; int c68; int c65; int c64; int total;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];
    int    errors = 0, checks = 0, acc = 0;
    bit    done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- monitor ----------------
    int n73 = 0, n68 = 0, n65 = 0, n64 = 0, vsum = 0, prev = 3;
    bit order_ok = 1;

    always @(negedge clk) begin
        if (rst) begin
            n73 = 0; n68 = 0; n65 = 0; n64 = 0; vsum = 0; prev = 3; order_ok = 1;
        end else begin
            case (mod_sel)
                2'b11: begin n73++; vsum += 73; end
                2'b10: begin n68++; vsum += 68; end
                2'b01: begin n65++; vsum += 65; end
                default: begin n64++; vsum += 64; end
            endcase
            if (int'(mod_sel) > prev) order_ok = 0;
            prev = int'(mod_sel);
            if (cmp_pulse) begin
                if (expq.size() == 0) begin
                    check(0, "R5", "unexpected pulse", 1, 0);
                end else begin
                    exp_t  e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    check(n73 == e.c73, "R1", {t, " count73"}, n73, e.c73);
                    check(n68 == e.c68, "R1", {t, " count68"}, n68, e.c68);
                    check(n65 == e.c65, "R3", {t, " count65"}, n65, e.c65);
                    check(n64 == e.c64, "R3", {t, " count64"}, n64, e.c64);
                    check(vsum == e.total, "R4", {t, " total"}, vsum, e.total);
                    check(order_ok, "R2", {t, " order"}, int'(order_ok), 1);
                    check(mod_sel == 2'b00, "R5", {t, " pulse modulus"}, int'(mod_sel), 0);
                end
                n73 = 0; n68 = 0; n65 = 0; n64 = 0; vsum = 0; prev = 3; order_ok = 1;
            end
        end
    end

    // ---------------- driver ----------------
    task automatic set_cfg(input int m64, input int m65, input int m68, input int m73,
                           input int ms, input int nf, input int d8);
        len64_m2 = 12'(m64); len65 = 8'(m65); len68_m1 = 4'(m68); len73_m1 = 4'(m73);
        mod_set = 2'(ms); frac_num = 3'(nf); frac_den8 = d8[0];
    endtask

    function automatic int step_acc(input int nf, input int d8);
        int q, a, f, s;
        q = d8 ? 8 : 5;
        a = (acc >= q) ? acc - q : acc;
        f = (nf >= q) ? q - 1 : nf;
        s = a + f;
        if (s >= q) begin acc = s - q; return 1; end
        acc = s;
        return 0;
    endfunction

    task automatic push(input string tag, input int c);
        exp_t e;
        bit h73, h68;
        h73 = (mod_set == 2'b11) || (mod_set == 2'b00);
        h68 = (mod_set == 2'b11) || (mod_set == 2'b10);
        e.c73 = h73 ? int'(len73_m1) + 1 : 0;
        e.c68 = h68 ? int'(len68_m1) + 1 : 0;
        e.c65 = int'(len65) + c;
        e.c64 = int'(len64_m2) + 2 - c;
        e.total = (int'(len64_m2) + 2) * 64 + int'(len65) * 65
                + (h68 ? (int'(len68_m1) + 1) * 68 : 0)
                + (h73 ? (int'(len73_m1) + 1) * 73 : 0) + c;
        expq.push_back(e);
        tagq.push_back(tag);
    endtask

    task automatic wait_end();
        do begin @(posedge clk); #1; end while (cmp_pulse !== 1'b1);
    endtask

    task automatic run(input int m64, input int m65, input int m68, input int m73,
                       input int ms, input int nf, input int d8, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            int c;
            wait_end();
            set_cfg(m64, m65, m68, m73, ms, nf, d8);
            c = step_acc(nf, d8);
            push(tag, c);
        end
    endtask

    task automatic do_reset(input int m64, input int m65, input int m68, input int m73,
                            input int ms, input int nf, input int d8, input string tag);
        int first;
        rst = 1'b1;
        expq.delete();
        tagq.delete();
        set_cfg(m64, m65, m68, m73, ms, nf, d8);
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        acc = 0;
        push(tag, 0);
        first = (ms == 3 || ms == 0) ? 3 : (ms == 2) ? 2 : (m65 > 0) ? 1 : 0;
        @(negedge clk);
        check(int'(mod_sel) == first, "R10", "first modulus after reset", int'(mod_sel), first);
        check(cmp_pulse == 1'b0, "R10", "no pulse in first cycle", int'(cmp_pulse), 0);
    endtask

    initial begin
        do_reset(3, 2, 1, 0, 3, 0, 0, "R10");
        run(3, 2, 1, 0, 3, 0, 0, 2, "R4");
        run(4, 1, 2, 3, 3, 2, 0, 10, "R6");
        run(2, 3, 5, 5, 1, 3, 1, 8, "R1 unused fields");
        run(1, 0, 2, 1, 2, 7, 1, 8, "R3 empty 65 segment");
        run(0, 0, 9, 2, 0, 6, 0, 6, "R7 numerator clamp");
        // R8: reach an accumulator of 7 in eighths, then switch to fifths
        do_reset(2, 1, 0, 0, 1, 7, 1, "R8");
        run(2, 1, 0, 0, 1, 7, 1, 1, "R8");
        run(2, 1, 0, 0, 1, 1, 0, 6, "R8 denominator switch");
        // R9: change fields mid-period; the period in progress keeps the old set
        wait_end();
        set_cfg(6, 1, 1, 1, 3, 0, 0);
        begin
            int c;
            c = step_acc(0, 0);
            push("R9 old set kept", c);
        end
        repeat (3) begin @(posedge clk); #1; end
        set_cfg(9, 2, 0, 0, 1, 0, 0);
        run(9, 2, 0, 0, 1, 0, 0, 1, "R9 new set at boundary");
        run(4095, 0, 0, 0, 1, 0, 0, 1, "R11 longest 64 segment");
        wait (expq.size() == 0);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R5 watchdog: pending periods actual=%0d expected=0", expq.size());
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule